// File: doc/BRIEF.md
# Descriptor Chain Command Processor

This block walks a linked list of six-word command descriptors held in system memory. Software writes the address of the first descriptor into the start-address register. The controller then reads the descriptor one word at a time over a simple read port and checks the header for odd parity and for a valid engine selector. It passes the header, the two length/pointer pairs and the engine choice to a data-path engine through a valid/ready handshake. It waits for the engine to finish and then follows the next pointer. A next pointer of zero ends the chain.

Progress is reported through a three-bit run state: idle, busy, error, fault or complete. An error source code, two address trackers and a maskable interrupt complete the report. Write-one command bits clear the interrupt and the error, issue a soft reset or select batch mode. A start address written while the controller is not idle is parked and launched as soon as the controller returns to idle.

Top module: `desc_chain_ctrl`

## Requirements
- R1: After reset the version register (0x00) reads 3, and status (0x10), error status (0x14) and control (0x08) read 0, with irq_o low.
- R2: Writing the start-address register (0x04) while idle makes status[2:0] read 1 (busy) from the next cycle. The current (0x1C) and initial (0x20) address registers both read the written address.
- R3: A descriptor is fetched as six word reads at ascending byte addresses base, base+4, ..., base+20, in the order header, len1, ptr1, len2, ptr2, next. The engine receives header, len1, ptr1, len2 and ptr2 unchanged, and eng_valid_o and its fields stay stable until eng_ready_i.
- R4: After eng_done_i without error, a nonzero next pointer starts a fetch at that address and updates the current-address register, while the initial-address register keeps the start address. A zero next pointer moves status[2:0] to 4 (complete).
- R5: A header with an even number of ones stops the walk before dispatch: status[2:0]=2 and error status[3:0]=2.
- R6: A header that passes parity but whose engine field [29:28] is neither 1 (cipher) nor 2 (hash) stops the walk before dispatch: status[2:0]=2 and error status[3:0]=3.
- R7: A memory response flagged with mem_err_i stops the walk: status[2:0]=2, error status[3:0]=15 and error status bit 8 (read direction) = 1.
- R8: eng_err_i together with eng_done_i stops the walk: status[2:0]=2, error status[3:0]=14 and bit 8 = 0.
- R9: A start or next address with bits [1:0] nonzero issues no memory read. It sets status[2:0]=3 (fault) and error status[3:0]=12, and the current-address register reads that address.
- R10: Entering error, fault or complete sets an interrupt-pending flag, and irq_o is that flag ANDed with control bit 4. Control keeps bits [31:16] and bit 4 as written, and all its other bits read 0.
- R11: Command bit 8 clears the pending interrupt and moves complete to idle. Error and fault stay until command bit 9, which moves them to idle and zeroes error status. Status bit 4 is 1 in error and fault.
- R12: A start-address write while not idle sets status bit 3 and is held. When the controller next becomes idle, the walk starts from the held address and bit 3 clears.
- R13: Command bit 0 aborts any walk, forces idle and clears the held address, interrupt, error status and address trackers. Command bit 16 sets status bit 16, which a soft reset leaves set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_en_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Register write when high |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on reg_addr_i |
| mem_req_o | output | 1 | Descriptor word read request, held until response |
| mem_addr_o | output | 32 | Byte address of requested word |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 32 | Read response data |
| mem_err_i | input | 1 | Read response carries a bus error |
| eng_valid_o | output | 1 | Descriptor offered to engine |
| eng_ready_i | input | 1 | Engine accepts descriptor |
| eng_hdr_o | output | 32 | Descriptor header |
| eng_len1_o | output | 32 | First length |
| eng_ptr1_o | output | 32 | First pointer |
| eng_len2_o | output | 32 | Second length |
| eng_ptr2_o | output | 32 | Second pointer |
| eng_done_i | input | 1 | Engine finished current descriptor |
| eng_err_i | input | 1 | Engine failure, valid with eng_done_i |
| irq_o | output | 1 | Interrupt request |

## Verification
A walker stuck in a wrong state shows first on mem_req_o, on mem_addr_o or on eng_valid_o. A missing request, a skipped or repeated address, or a dispatch of a header that fails parity is visible in the same cycle, and the bench logs every fetch address. A wrong run state or error code shows in the status and error-status reads, and in irq_o once the walk settles, a few tens of cycles after the start write. A lost or stale held address shows as status bit 3 failing to clear, or as the initial-address register reading the wrong chain after the clear command.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int DESC_WORDS = 6;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BUSY  = 3'd1,
    ST_ERROR = 3'd2,
    ST_FAULT = 3'd3,
    ST_DONE  = 3'd4
  } run_state_e;

  typedef enum logic [2:0] {
    W_IDLE, W_FETCH, W_ISSUE, W_WAIT, W_DONE, W_ERR, W_FAULT
  } walk_e;

  localparam logic [3:0] SRC_PARITY = 4'd2;
  localparam logic [3:0] SRC_ENGSEL = 4'd3;
  localparam logic [3:0] SRC_ALIGN  = 4'd12;
  localparam logic [3:0] SRC_ENGINE = 4'd14;
  localparam logic [3:0] SRC_DMA    = 4'd15;

  localparam logic [7:0] OFS_VER  = 8'h00;
  localparam logic [7:0] OFS_DAR  = 8'h04;
  localparam logic [7:0] OFS_CTRL = 8'h08;
  localparam logic [7:0] OFS_CMD  = 8'h0C;
  localparam logic [7:0] OFS_STAT = 8'h10;
  localparam logic [7:0] OFS_ERR  = 8'h14;
  localparam logic [7:0] OFS_CUR  = 8'h1C;
  localparam logic [7:0] OFS_INIT = 8'h20;
endpackage

// File: rtl/dcc_walker.sv
module dcc_walker
  import dcc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          clr_int_i,
  input  logic          clr_err_i,
  input  logic          soft_rst_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [31:0]   mem_rdata_i,
  input  logic          mem_err_i,
  output logic          eng_valid_o,
  input  logic          eng_ready_i,
  output logic [31:0]   eng_hdr_o,
  output logic [31:0]   eng_len1_o,
  output logic [31:0]   eng_ptr1_o,
  output logic [31:0]   eng_len2_o,
  output logic [31:0]   eng_ptr2_o,
  input  logic          eng_done_i,
  input  logic          eng_err_i,
  output logic [2:0]    state_o,
  output logic          idle_o,
  output logic [3:0]    err_src_o,
  output logic          err_dir_o,
  output logic [AW-1:0] cur_addr_o,
  output logic [AW-1:0] init_addr_o,
  output logic          int_pend_o
);
  localparam int IDX_W = $clog2(DESC_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  walk_e            walk_q;
  logic [IDX_W-1:0] idx_q;
  logic [31:0]      words_q [DESC_WORDS];
  logic [AW-1:0]    cur_q, init_q;
  logic [3:0]       src_q;
  logic             dir_q, pend_q;
  logic [AW-1:0]    next_w;
  logic [1:0]       sel_w;

  assign next_w = words_q[DESC_WORDS-1][AW-1:0];
  assign sel_w  = mem_rdata_i[29:28];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      walk_q <= W_IDLE;
      idx_q  <= '0;
      cur_q  <= '0;
      init_q <= '0;
      src_q  <= '0;
      dir_q  <= 1'b0;
      pend_q <= 1'b0;
      for (int i = 0; i < DESC_WORDS; i++) words_q[i] <= '0;
    end else if (soft_rst_i) begin
      walk_q <= W_IDLE;
      idx_q  <= '0;
      cur_q  <= '0;
      init_q <= '0;
      src_q  <= '0;
      dir_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (clr_int_i) pend_q <= 1'b0;
      case (walk_q)
        W_IDLE: if (start_i) begin
          init_q <= start_addr_i;
          cur_q  <= start_addr_i;
          idx_q  <= '0;
          if (start_addr_i[1:0] != 2'b00) begin
            walk_q <= W_FAULT;
            src_q  <= SRC_ALIGN;
            pend_q <= 1'b1;
          end else begin
            walk_q <= W_FETCH;
          end
        end
        W_FETCH: if (mem_rvalid_i) begin
          if (mem_err_i) begin
            walk_q <= W_ERR;
            src_q  <= SRC_DMA;
            dir_q  <= 1'b1;
            pend_q <= 1'b1;
          end else if (idx_q == '0 && !(^mem_rdata_i)) begin
            walk_q <= W_ERR;
            src_q  <= SRC_PARITY;
            pend_q <= 1'b1;
          end else if (idx_q == '0 && (sel_w == 2'd0 || sel_w == 2'd3)) begin
            walk_q <= W_ERR;
            src_q  <= SRC_ENGSEL;
            pend_q <= 1'b1;
          end else begin
            words_q[idx_q] <= mem_rdata_i;
            if (idx_q == LAST_IDX) walk_q <= W_ISSUE;
            else idx_q <= idx_q + 1'b1;
          end
        end
        W_ISSUE: if (eng_ready_i) walk_q <= W_WAIT;
        W_WAIT: if (eng_done_i) begin
          if (eng_err_i) begin
            walk_q <= W_ERR;
            src_q  <= SRC_ENGINE;
            pend_q <= 1'b1;
          end else if (next_w == '0) begin
            walk_q <= W_DONE;
            pend_q <= 1'b1;
          end else begin
            cur_q <= next_w;
            idx_q <= '0;
            if (next_w[1:0] != 2'b00) begin
              walk_q <= W_FAULT;
              src_q  <= SRC_ALIGN;
              pend_q <= 1'b1;
            end else begin
              walk_q <= W_FETCH;
            end
          end
        end
        W_DONE: if (clr_int_i) walk_q <= W_IDLE;
        W_ERR, W_FAULT: if (clr_err_i) begin
          walk_q <= W_IDLE;
          src_q  <= '0;
          dir_q  <= 1'b0;
          pend_q <= 1'b0;
        end
        default: walk_q <= W_IDLE;
      endcase
    end
  end

  always_comb begin
    case (walk_q)
      W_IDLE:  state_o = ST_IDLE;
      W_ERR:   state_o = ST_ERROR;
      W_FAULT: state_o = ST_FAULT;
      W_DONE:  state_o = ST_DONE;
      default: state_o = ST_BUSY;
    endcase
  end

  assign idle_o      = (walk_q == W_IDLE);
  assign mem_req_o   = (walk_q == W_FETCH);
  assign mem_addr_o  = cur_q + AW'({idx_q, 2'b00});
  assign eng_valid_o = (walk_q == W_ISSUE);
  assign eng_hdr_o   = words_q[0];
  assign eng_len1_o  = words_q[1];
  assign eng_ptr1_o  = words_q[2];
  assign eng_len2_o  = words_q[3];
  assign eng_ptr2_o  = words_q[4];
  assign err_src_o   = src_q;
  assign err_dir_o   = dir_q;
  assign cur_addr_o  = cur_q;
  assign init_addr_o = init_q;
  assign int_pend_o  = pend_q;

  // R9
  mem_addr_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

  // R3
  issue_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_valid_o && !eng_ready_i && !soft_rst_i |=>
      eng_valid_o && $stable(eng_hdr_o) && $stable(eng_ptr1_o) && $stable(eng_ptr2_o));

  // R5
  issue_parity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_valid_o |-> ^eng_hdr_o);

  // R2
  start_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && state_o == ST_IDLE && !soft_rst_i |=>
      state_o == ST_BUSY || state_o == ST_FAULT);

  // R10
  pend_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_pend_o) |->
      state_o == ST_ERROR || state_o == ST_FAULT || state_o == ST_DONE);
endmodule

// File: rtl/dcc_regs.sv
module dcc_regs
  import dcc_pkg::*;
#(
  parameter int AW      = 32,
  parameter int REG_AW  = 8,
  parameter int VERSION = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_en_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              idle_i,
  input  logic [2:0]        state_i,
  input  logic [3:0]        err_src_i,
  input  logic              err_dir_i,
  input  logic [AW-1:0]     cur_i,
  input  logic [AW-1:0]     init_i,
  input  logic              int_pend_i,
  output logic              start_o,
  output logic [AW-1:0]     start_addr_o,
  output logic              clr_int_o,
  output logic              clr_err_o,
  output logic              soft_rst_o,
  output logic              irq_o
);
  localparam logic [31:0] CTRL_MASK = 32'hFFFF_0010;

  logic          wr_w, dar_wr_w, cmd_wr_w;
  logic [31:0]   ctrl_q, dar_q;
  logic          batch_q, pend_full_q;
  logic [AW-1:0] pend_addr_q;
  logic          err_w;

  assign wr_w     = reg_en_i && reg_we_i;
  assign dar_wr_w = wr_w && (reg_addr_i == REG_AW'(OFS_DAR));
  assign cmd_wr_w = wr_w && (reg_addr_i == REG_AW'(OFS_CMD));

  assign soft_rst_o   = cmd_wr_w && reg_wdata_i[0];
  assign clr_int_o    = cmd_wr_w && reg_wdata_i[8];
  assign clr_err_o    = cmd_wr_w && reg_wdata_i[9];
  assign start_o      = idle_i && !soft_rst_o && (dar_wr_w || pend_full_q);
  assign start_addr_o = dar_wr_w ? reg_wdata_i[AW-1:0] : pend_addr_q;
  assign irq_o        = int_pend_i && ctrl_q[4];
  assign err_w        = (state_i == ST_ERROR) || (state_i == ST_FAULT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= '0;
      dar_q       <= '0;
      batch_q     <= 1'b0;
      pend_full_q <= 1'b0;
      pend_addr_q <= '0;
    end else begin
      if (wr_w && reg_addr_i == REG_AW'(OFS_CTRL)) ctrl_q <= reg_wdata_i & CTRL_MASK;
      if (dar_wr_w) dar_q <= reg_wdata_i;
      if (cmd_wr_w && reg_wdata_i[16]) batch_q <= 1'b1;
      if (soft_rst_o) begin
        pend_full_q <= 1'b0;
      end else if (dar_wr_w && !idle_i) begin
        pend_full_q <= 1'b1;
        pend_addr_q <= reg_wdata_i[AW-1:0];
      end else if (start_o) begin
        pend_full_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (reg_addr_i)
      REG_AW'(OFS_VER):  reg_rdata_o = 32'(VERSION);
      REG_AW'(OFS_DAR):  reg_rdata_o = dar_q;
      REG_AW'(OFS_CTRL): reg_rdata_o = ctrl_q;
      REG_AW'(OFS_STAT): reg_rdata_o = {15'b0, batch_q, 11'b0, err_w, pend_full_q, state_i};
      REG_AW'(OFS_ERR):  reg_rdata_o = {23'b0, err_dir_i, 4'b0, err_src_i};
      REG_AW'(OFS_CUR):  reg_rdata_o = 32'(cur_i);
      REG_AW'(OFS_INIT): reg_rdata_o = 32'(init_i);
      default:           reg_rdata_o = '0;
    endcase
  end

  // R12
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_full_q && !idle_i && !soft_rst_o |=> pend_full_q);

  // R13
  soft_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !pend_full_q && !irq_o);
endmodule

// File: rtl/desc_chain_ctrl.sv
module desc_chain_ctrl
  import dcc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int REG_AW  = 8,
  parameter int VERSION = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_en_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  input  logic              mem_err_i,
  output logic              eng_valid_o,
  input  logic              eng_ready_i,
  output logic [31:0]       eng_hdr_o,
  output logic [31:0]       eng_len1_o,
  output logic [31:0]       eng_ptr1_o,
  output logic [31:0]       eng_len2_o,
  output logic [31:0]       eng_ptr2_o,
  input  logic              eng_done_i,
  input  logic              eng_err_i,
  output logic              irq_o
);
  logic              start_w, clr_int_w, clr_err_w, soft_rst_w;
  logic [ADDR_W-1:0] start_addr_w, cur_w, init_w;
  logic [2:0]        state_w;
  logic              idle_w, dir_w, pend_w;
  logic [3:0]        src_w;

  dcc_regs #(.AW(ADDR_W), .REG_AW(REG_AW), .VERSION(VERSION)) u_regs (
    .clk_i, .rst_ni, .reg_en_i, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .idle_i(idle_w), .state_i(state_w), .err_src_i(src_w), .err_dir_i(dir_w),
    .cur_i(cur_w), .init_i(init_w), .int_pend_i(pend_w),
    .start_o(start_w), .start_addr_o(start_addr_w), .clr_int_o(clr_int_w),
    .clr_err_o(clr_err_w), .soft_rst_o(soft_rst_w), .irq_o
  );

  dcc_walker #(.AW(ADDR_W)) u_walker (
    .clk_i, .rst_ni,
    .start_i(start_w), .start_addr_i(start_addr_w), .clr_int_i(clr_int_w),
    .clr_err_i(clr_err_w), .soft_rst_i(soft_rst_w),
    .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i, .mem_err_i,
    .eng_valid_o, .eng_ready_i, .eng_hdr_o, .eng_len1_o, .eng_ptr1_o,
    .eng_len2_o, .eng_ptr2_o, .eng_done_i, .eng_err_i,
    .state_o(state_w), .idle_o(idle_w), .err_src_o(src_w), .err_dir_o(dir_w),
    .cur_addr_o(cur_w), .init_addr_o(init_w), .int_pend_o(pend_w)
  );
endmodule

// File: tb/desc_chain_ctrl_bench.sv
module desc_chain_ctrl_bench;
  localparam logic [7:0] A_VER = 8'h00, A_DAR = 8'h04, A_CTRL = 8'h08, A_CMD = 8'h0C,
                         A_STAT = 8'h10, A_ERR = 8'h14, A_CUR = 8'h1C, A_INIT = 8'h20;

  typedef struct packed {
    logic [31:0] hdr;
    logic        mem_fail;
    logic        eng_fail;
    logic [2:0]  st;
    logic [8:0]  es;
    logic        disp;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{32'h9085_0000, 1'b0, 1'b0, 3'd4, 9'h000, 1'b1},
    '{32'hA085_0000, 1'b0, 1'b0, 3'd4, 9'h000, 1'b1},
    '{32'h1085_0000, 1'b0, 1'b0, 3'd2, 9'h002, 1'b0},
    '{32'h0085_0000, 1'b0, 1'b0, 3'd2, 9'h003, 1'b0},
    '{32'h3085_0000, 1'b0, 1'b0, 3'd2, 9'h003, 1'b0},
    '{32'h9085_0000, 1'b1, 1'b0, 3'd2, 9'h10F, 1'b0},
    '{32'h9085_0000, 1'b0, 1'b1, 3'd2, 9'h00E, 1'b1}
  };
  localparam string TAGS [NV] = '{"R3", "R4", "R5", "R6", "R6", "R7", "R8"};

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        reg_en = 0, reg_we = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        mem_req, mem_rvalid = 0, mem_err = 0;
  logic [31:0] mem_addr, mem_rdata = 0;
  logic        eng_valid, eng_ready = 1, eng_done = 0, eng_err = 0;
  logic [31:0] eng_hdr, eng_len1, eng_ptr1, eng_len2, eng_ptr2;
  logic        irq;

  logic [31:0] mem [256];
  logic [31:0] bad_addr = 32'hFFFF_FFF0;
  logic        eng_fail = 0, done_cd = 0;
  int          fetch_cnt = 0, disp_cnt = 0;
  logic [31:0] fetch_log [64];
  logic [31:0] cap_hdr, cap_len1, cap_ptr1, cap_ptr2;
  int          checks = 0, errors = 0;

  desc_chain_ctrl u_desc_chain_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_en_i(reg_en), .reg_we_i(reg_we),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .mem_err_i(mem_err),
    .eng_valid_o(eng_valid), .eng_ready_i(eng_ready), .eng_hdr_o(eng_hdr),
    .eng_len1_o(eng_len1), .eng_ptr1_o(eng_ptr1), .eng_len2_o(eng_len2),
    .eng_ptr2_o(eng_ptr2), .eng_done_i(eng_done), .eng_err_i(eng_err), .irq_o(irq)
  );

  // memory responder: one word per request, one cycle latency
  always @(posedge clk) begin
    mem_rvalid <= mem_req && !mem_rvalid;
    mem_rdata  <= mem[mem_addr[9:2]];
    mem_err    <= mem_req && !mem_rvalid && (mem_addr == bad_addr);
    if (mem_req && !mem_rvalid) begin
      fetch_log[fetch_cnt % 64] <= mem_addr;
      fetch_cnt <= fetch_cnt + 1;
    end
  end

  // engine model: accept, then finish two cycles later
  always @(posedge clk) begin
    eng_done <= 1'b0;
    eng_err  <= 1'b0;
    if (eng_valid && eng_ready) begin
      cap_hdr  <= eng_hdr;
      cap_len1 <= eng_len1;
      cap_ptr1 <= eng_ptr1;
      cap_ptr2 <= eng_ptr2;
      disp_cnt <= disp_cnt + 1;
      done_cd  <= 1'b1;
    end else if (done_cd) begin
      eng_done <= 1'b1;
      eng_err  <= eng_fail;
      done_cd  <= 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic settle(input string tag);
    logic [31:0] s;
    int n = 0;
    do begin
      @(negedge clk);
      rd(A_STAT, s);
      n++;
    end while (s[2:0] < 3'd2 && n < 400);
    if (n >= 400) chk({tag, " settle"}, s, 32'h4);
  endtask

  task automatic put_desc(input logic [31:0] b, input logic [31:0] h, input logic [31:0] l1,
                          input logic [31:0] p1, input logic [31:0] l2, input logic [31:0] p2,
                          input logic [31:0] nx);
    mem[b[9:2]]     = h;
    mem[b[9:2] + 1] = l1;
    mem[b[9:2] + 2] = p1;
    mem[b[9:2] + 3] = l2;
    mem[b[9:2] + 4] = p2;
    mem[b[9:2] + 5] = nx;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int d0, f0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(A_VER, r);  chk("R1 version", r, 32'd3);
    rd(A_STAT, r); chk("R1 status", r, 32'h0);
    rd(A_ERR, r);  chk("R1 errstat", r, 32'h0);
    rd(A_CTRL, r); chk("R1 control", r, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);

    // R10 control readback
    wr(A_CTRL, 32'hABCD_00FF);
    rd(A_CTRL, r); chk("R10 ctrl mask", r, 32'hABCD_0010);
    wr(A_CTRL, 32'h10);

    // vector table
    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      put_desc(32'h100, v.hdr, 32'h10 + i, 32'h1000 + i, 32'h20 + i, 32'h2000 + i, 32'h0);
      bad_addr = v.mem_fail ? 32'h10C : 32'hFFFF_FFF0;
      eng_fail = v.eng_fail;
      d0 = disp_cnt;
      wr(A_DAR, 32'h100);
      settle(TAGS[i]);
      rd(A_STAT, r); chk({TAGS[i], " state"}, 32'(r[2:0]), 32'(v.st));
      rd(A_ERR, r);  chk({TAGS[i], " errstat"}, r, {23'b0, v.es});
      chk({TAGS[i], " dispatch"}, disp_cnt - d0, 32'(v.disp));
      if (v.disp) begin
        chk("R3 hdr", cap_hdr, v.hdr);
        chk("R3 len1", cap_len1, 32'h10 + i);
        chk("R3 ptr1", cap_ptr1, 32'h1000 + i);
        chk("R3 ptr2", cap_ptr2, 32'h2000 + i);
      end
      chk("R10 irq", 32'(irq), 32'h1);
      wr(A_CMD, 32'h300);
      rd(A_STAT, r); chk("R11 cleared", r, 32'h0);
    end
    bad_addr = 32'hFFFF_FFF0;
    eng_fail = 0;

    // R2 start and R3 address order
    put_desc(32'h100, 32'h9085_0000, 1, 2, 3, 4, 0);
    f0 = fetch_cnt;
    wr(A_DAR, 32'h100);
    rd(A_STAT, r); chk("R2 busy", r, 32'h1);
    rd(A_INIT, r); chk("R2 init", r, 32'h100);
    rd(A_CUR, r);  chk("R2 cur", r, 32'h100);
    settle("R2");
    for (int k = 0; k < 6; k++) chk("R3 fetch addr", fetch_log[(f0 + k) % 64], 32'h100 + 4 * k);
    chk("R3 fetch count", fetch_cnt - f0, 32'd6);
    wr(A_CMD, 32'h100);

    // R4 two-descriptor chain
    put_desc(32'h200, 32'h9085_0000, 1, 32'h5555, 3, 4, 32'h240);
    put_desc(32'h240, 32'hA085_0000, 1, 32'h7777, 3, 4, 32'h0);
    d0 = disp_cnt;
    wr(A_DAR, 32'h200);
    settle("R4");
    rd(A_STAT, r); chk("R4 complete", r, 32'h4);
    chk("R4 dispatches", disp_cnt - d0, 32'd2);
    chk("R4 second ptr1", cap_ptr1, 32'h7777);
    rd(A_CUR, r);  chk("R4 cur", r, 32'h240);
    rd(A_INIT, r); chk("R4 init", r, 32'h200);
    wr(A_CMD, 32'h100);

    // R9 unaligned start and unaligned next
    f0 = fetch_cnt;
    wr(A_DAR, 32'h102);
    rd(A_STAT, r); chk("R9 fault status", r, 32'h13);
    rd(A_ERR, r);  chk("R9 src", r, 32'hC);
    repeat (3) @(negedge clk);
    chk("R9 no fetch", fetch_cnt - f0, 32'd0);
    wr(A_CMD, 32'h200);
    put_desc(32'h300, 32'h9085_0000, 1, 2, 3, 4, 32'h306);
    wr(A_DAR, 32'h300);
    settle("R9");
    rd(A_STAT, r); chk("R9 next fault", 32'(r[2:0]), 32'd3);
    rd(A_CUR, r);  chk("R9 cur", r, 32'h306);
    wr(A_CMD, 32'h200);

    // R10 masked interrupt, R11 clear interrupt
    wr(A_CTRL, 32'h0);
    wr(A_DAR, 32'h100);
    settle("R10");
    chk("R10 masked irq", 32'(irq), 32'h0);
    wr(A_CTRL, 32'h10);
    chk("R10 unmasked irq", 32'(irq), 32'h1);
    wr(A_CMD, 32'h100);
    rd(A_STAT, r); chk("R11 complete to idle", r, 32'h0);
    chk("R11 irq cleared", 32'(irq), 32'h0);

    // R11 error needs bit 9
    put_desc(32'h100, 32'h1085_0000, 1, 2, 3, 4, 0);
    wr(A_DAR, 32'h100);
    settle("R11");
    wr(A_CMD, 32'h100);
    rd(A_STAT, r); chk("R11 error kept", r, 32'h12);
    chk("R11 irq off", 32'(irq), 32'h0);
    wr(A_CMD, 32'h200);
    rd(A_STAT, r); chk("R11 error cleared", r, 32'h0);
    rd(A_ERR, r);  chk("R11 errstat cleared", r, 32'h0);

    // R12 held start address
    put_desc(32'h100, 32'h9085_0000, 1, 2, 3, 4, 0);
    put_desc(32'h180, 32'hA085_0000, 1, 32'h8888, 3, 4, 0);
    wr(A_DAR, 32'h100);
    wr(A_DAR, 32'h180);
    rd(A_STAT, r); chk("R12 full busy", r, 32'h9);
    rd(A_DAR, r);  chk("R12 dar read", r, 32'h180);
    settle("R12");
    rd(A_STAT, r); chk("R12 full complete", r, 32'hC);
    rd(A_INIT, r); chk("R12 first init", r, 32'h100);
    wr(A_CMD, 32'h100);
    rd(A_STAT, r); chk("R12 idle with held", r, 32'h8);
    settle("R12");
    rd(A_STAT, r); chk("R12 second done", r, 32'h4);
    rd(A_INIT, r); chk("R12 second init", r, 32'h180);
    chk("R12 second ptr1", cap_ptr1, 32'h8888);
    wr(A_CMD, 32'h100);

    // R13 soft reset and batch mode
    wr(A_DAR, 32'h100);
    wr(A_DAR, 32'h180);
    wr(A_CMD, 32'h1);
    rd(A_STAT, r); chk("R13 soft idle", r, 32'h0);
    rd(A_CUR, r);  chk("R13 cur cleared", r, 32'h0);
    chk("R13 irq", 32'(irq), 32'h0);
    repeat (20) @(negedge clk);
    rd(A_STAT, r); chk("R13 held dropped", r, 32'h0);
    wr(A_CMD, 32'h1_0000);
    rd(A_STAT, r); chk("R13 batch", r, 32'h1_0000);
    wr(A_CMD, 32'h1);
    rd(A_STAT, r); chk("R13 batch kept", r, 32'h1_0000);
    rd(A_CTRL, r); chk("R13 ctrl kept", r, 32'h10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule